// File: doc/BRIEF.md
# Watchdog Countdown and Interrupt Router

This block keeps a four-digit BCD watchdog period in two byte registers and counts it down, one step per hundredth-of-a-second enable. The host keeps the watchdog quiet by touching either period register. A read or a write is enough. If the host stops, the countdown reaches zero, raises the watchdog flag, reloads itself and starts again.

A command register picks which of two interrupt lines carries the watchdog event and which carries the time-of-day alarm event. The time-of-day event arrives from a neighbouring calendar block. The command register also masks each event at the pins, selects the polarity of the second line, and chooses level or pulse output. In pulse mode a flag lasts only while its pulse lasts, and a 1 kHz enable times the pulse. Pad drive is left to the pad ring: the block only reports the chosen polarity of line B.

Top module: `wdg_irq_ctrl`

## Requirements
- R1: With a nonzero stored period of N hundredths, the watchdog flag (command bit 1) sets on the N-th hundredth tick after the last period-register access, and not before.
- R2: When no period-register access follows an alarm, the countdown reloads itself and raises the alarm again after another N hundredth ticks.
- R3: Any access to either period register, read or write, clears the watchdog flag and restarts the countdown from the full stored period.
- R4: The low period byte (hundredths) and the high period byte (seconds) always read back the stored value, never the live count.
- R5: A stored period of 00.00 stops the watchdog, so that no alarm occurs however many ticks arrive.
- R6: The countdown borrows in decimal across all four digits, so that a period of 01.00 alarms on exactly the 100th tick.
- R7: Command bit 6 set to 1 sends the time-of-day event to line A and the watchdog to line B; set to 0, it sends the watchdog to A and the time-of-day event to B. Line A is active low.
- R8: Command bit 3 masks the watchdog event and bit 2 masks the time-of-day event at the lines; a masked flag still sets and still reads back.
- R9: Command bit 5 set to 1 makes line B active high, and 0 makes it active low; `irq_b_hi_o` mirrors this bit.
- R10: With command bit 4 set to 1, each flag clears by itself on the third 1 kHz tick after it sets; with bit 4 at 0 it holds until cleared.
- R11: The time-of-day flag (command bit 0) sets on `tod_evt_i` and clears on `tod_ack_i`; when both arrive in the same cycle, the flag sets.
- R12: Writes to command bits 1 and 0 are ignored. The command register resets to 0x0C, which masks both events with line B active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_cs_i | input | 1 | Hundredth-second enable, one cycle wide |
| tick_ms_i | input | 1 | 1 kHz enable that times pulses |
| tod_evt_i | input | 1 | Time-of-day alarm event, one cycle wide |
| tod_ack_i | input | 1 | Access to the alarm-time registers, clears the time-of-day flag |
| cmd_sel_i | input | 1 | Access strobe for the command register |
| wdl_sel_i | input | 1 | Access strobe for the hundredths period register |
| wdh_sel_i | input | 1 | Access strobe for the seconds period register |
| wr_i | input | 1 | The access is a write when high |
| wdata_i | input | 8 | Write data |
| irq_a_n_o | output | 1 | Interrupt line A, active low |
| irq_b_o | output | 1 | Interrupt line B, polarity given by command bit 5 |
| irq_b_hi_o | output | 1 | High when line B is active high |
| cmd_o | output | 8 | Command register readback, including both flags |
| wdl_o | output | 8 | Stored hundredths period, BCD |
| wdh_o | output | 8 | Stored seconds period, BCD |

## Verification
The digit assertions on the countdown take for granted that every period byte written holds two valid BCD digits. The bench writes only such values. The assertions also take for granted that the enables and strobes are single-cycle pulses, with at most one period-register access in any cycle. The bench drives each enable and strobe for exactly one cycle from its tasks, and it never overlaps two period accesses.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned CMD_XFER  = 7;
  localparam int unsigned CMD_ROUTE = 6;
  localparam int unsigned CMD_BPOL  = 5;
  localparam int unsigned CMD_PULSE = 4;
  localparam int unsigned CMD_WMSK  = 3;
  localparam int unsigned CMD_TMSK  = 2;
  localparam int unsigned CMD_WFLG  = 1;
  localparam int unsigned CMD_TFLG  = 0;
  localparam logic [7:0]  CMD_RESET = 8'h0C;
endpackage

// File: rtl/wdg_bcd_down.sv
module wdg_bcd_down #(
  parameter int unsigned NDIG = 4,
  localparam int unsigned W = 4 * NDIG
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] val_i,
  input  logic         tick_i,
  output logic         fire_o
);
  logic [W-1:0] cnt_q;
  logic         run;

  function automatic logic [W-1:0] bcd_dec(input logic [W-1:0] v);
    logic [W-1:0] r;
    logic borrow;
    r = v;
    borrow = 1'b1;
    for (int i = 0; i < NDIG; i++) begin
      if (borrow) begin
        if (v[4*i +: 4] == 4'd0) begin
          r[4*i +: 4] = 4'd9;
        end else begin
          r[4*i +: 4] = v[4*i +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  assign run    = (val_i != '0) && tick_i && !load_i;
  assign fire_o = run && (cnt_q == W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (fire_o)  cnt_q <= val_i;
    else if (run && cnt_q != '0) cnt_q <= bcd_dec(cnt_q);
  end

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i)); // R3

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    AST_DIGIT_BCD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q[4*g +: 4] <= 4'd9); // R6
  end
endmodule

// File: rtl/wdg_evt_flag.sv
module wdg_evt_flag #(
  parameter int unsigned PULSE_TICKS = 3,
  localparam int unsigned CW = $clog2(PULSE_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic pulse_i,
  input  logic tick_i,
  output logic flag_o
);
  logic [CW-1:0] pcnt_q;
  logic          expire;

  assign expire = flag_o && pulse_i && tick_i && (pcnt_q == CW'(PULSE_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      pcnt_q <= '0;
    end else if (set_i) begin
      flag_o <= 1'b1;
      pcnt_q <= '0;
    end else if (clr_i || expire) begin
      flag_o <= 1'b0;
      pcnt_q <= '0;
    end else if (flag_o && pulse_i && tick_i) begin
      pcnt_q <= pcnt_q + CW'(1);
    end
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o); // R11
  AST_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !flag_o); // R11
  AST_PULSE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) && !$past(clr_i) |-> $past(tick_i) && $past(pulse_i)); // R10
endmodule

// File: rtl/wdg_irq_ctrl.sv
module wdg_irq_ctrl
  import wdg_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned PULSE_TICKS = 3,
  localparam int unsigned NDIG       = 2 * DW / 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_cs_i,
  input  logic          tick_ms_i,
  input  logic          tod_evt_i,
  input  logic          tod_ack_i,
  input  logic          cmd_sel_i,
  input  logic          wdl_sel_i,
  input  logic          wdh_sel_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          irq_a_n_o,
  output logic          irq_b_o,
  output logic          irq_b_hi_o,
  output logic [7:0]    cmd_o,
  output logic [DW-1:0] wdl_o,
  output logic [DW-1:0] wdh_o
);
  logic [7:2]    cmd_q;
  logic [DW-1:0] lo_q, hi_q, lo_d, hi_d;
  logic          wd_acc, wd_fire;
  logic          wflag, tflag;
  logic          w_act, t_act, a_act, b_act;

  assign wd_acc = wdl_sel_i || wdh_sel_i;
  assign lo_d   = (wdl_sel_i && wr_i) ? wdata_i : lo_q;
  assign hi_d   = (wdh_sel_i && wr_i) ? wdata_i : hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= CMD_RESET[7:2];
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      if (cmd_sel_i && wr_i) cmd_q <= wdata_i[7:2];
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  wdg_bcd_down #(.NDIG(NDIG)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wd_acc),
    .load_val_i ({hi_d, lo_d}),
    .val_i      ({hi_q, lo_q}),
    .tick_i     (tick_cs_i),
    .fire_o     (wd_fire)
  );

  wdg_evt_flag #(.PULSE_TICKS(PULSE_TICKS)) u_wflag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (wd_fire),
    .clr_i   (wd_acc),
    .pulse_i (cmd_q[CMD_PULSE]),
    .tick_i  (tick_ms_i),
    .flag_o  (wflag)
  );

  wdg_evt_flag #(.PULSE_TICKS(PULSE_TICKS)) u_tflag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (tod_evt_i),
    .clr_i   (tod_ack_i),
    .pulse_i (cmd_q[CMD_PULSE]),
    .tick_i  (tick_ms_i),
    .flag_o  (tflag)
  );

  assign w_act = wflag && !cmd_q[CMD_WMSK];
  assign t_act = tflag && !cmd_q[CMD_TMSK];
  assign a_act = cmd_q[CMD_ROUTE] ? t_act : w_act;
  assign b_act = cmd_q[CMD_ROUTE] ? w_act : t_act;

  assign irq_a_n_o  = !a_act;
  assign irq_b_hi_o = cmd_q[CMD_BPOL];
  assign irq_b_o    = cmd_q[CMD_BPOL] ? b_act : !b_act;
  assign cmd_o      = {cmd_q, wflag, tflag};
  assign wdl_o      = lo_q;
  assign wdh_o      = hi_q;

  AST_MASKED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[CMD_WMSK] && cmd_o[CMD_TMSK] |-> irq_a_n_o && (irq_b_o == !irq_b_hi_o)); // R8
  AST_ACC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_acc |=> !cmd_o[CMD_WFLG]); // R3
  AST_LO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wdl_sel_i && wr_i) |=> $stable(wdl_o)); // R4
  AST_HI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wdh_sel_i && wr_i) |=> $stable(wdh_o)); // R4
  AST_ZERO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdl_o == '0 && wdh_o == '0 && !wd_acc && !$past(wd_acc) |-> !$rose(cmd_o[CMD_WFLG])); // R5
endmodule

// File: tb/sim_wdg_irq_ctrl.sv
module sim_wdg_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic tick_cs = 0, tick_ms = 0, tod_evt = 0, tod_ack = 0;
  logic cmd_sel = 0, wdl_sel = 0, wdh_sel = 0, wr = 0;
  logic [7:0] wdata = 0;
  logic irq_a_n, irq_b, irq_b_hi;
  logic [7:0] cmd_r, wdl_r, wdh_r;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdg_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_cs_i(tick_cs), .tick_ms_i(tick_ms),
    .tod_evt_i(tod_evt), .tod_ack_i(tod_ack), .cmd_sel_i(cmd_sel),
    .wdl_sel_i(wdl_sel), .wdh_sel_i(wdh_sel), .wr_i(wr), .wdata_i(wdata),
    .irq_a_n_o(irq_a_n), .irq_b_o(irq_b), .irq_b_hi_o(irq_b_hi),
    .cmd_o(cmd_r), .wdl_o(wdl_r), .wdh_o(wdh_r)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cs(int n);
    repeat (n) begin tick_cs = 1; @(negedge clk); tick_cs = 0; end
  endtask
  task automatic ms(int n);
    repeat (n) begin tick_ms = 1; @(negedge clk); tick_ms = 0; end
  endtask
  // sel: 0 cmd, 1 low period, 2 high period
  task automatic acc(int sel, logic w, logic [7:0] d);
    cmd_sel = (sel == 0); wdl_sel = (sel == 1); wdh_sel = (sel == 2);
    wr = w; wdata = d;
    @(negedge clk);
    cmd_sel = 0; wdl_sel = 0; wdh_sel = 0; wr = 0;
  endtask
  task automatic tod(logic e, logic a);
    tod_evt = e; tod_ack = a; @(negedge clk); tod_evt = 0; tod_ack = 0;
  endtask

  task automatic t_reset;
    check("R12 reset cmd", cmd_r, 8'h0C);
    check("R12 reset A idle", {7'd0, irq_a_n}, 8'd1);
    check("R9 reset B idle low-active", {6'd0, irq_b, irq_b_hi}, 8'b10);
  endtask

  task automatic t_countdown;
    acc(0, 1, 8'h00);
    acc(1, 1, 8'h03);
    acc(2, 1, 8'h00);
    cs(2);
    check("R1 no flag before N", {7'd0, cmd_r[1]}, 8'd0);
    cs(1);
    check("R1 flag at N", {7'd0, cmd_r[1]}, 8'd1);
    check("R7 wd on A when route 0", {7'd0, irq_a_n}, 8'd0);
    check("R4 low readback", wdl_r, 8'h03);
    check("R4 high readback", wdh_r, 8'h00);
  endtask

  task automatic t_reload;
    acc(1, 0, 8'h00);
    check("R3 read clears flag", {7'd0, cmd_r[1]}, 8'd0);
    check("R4 read keeps value", wdl_r, 8'h03);
    cs(2);
    check("R3 restarted count", {7'd0, cmd_r[1]}, 8'd0);
    cs(1);
    check("R3 full period after read", {7'd0, cmd_r[1]}, 8'd1);
    acc(2, 0, 8'h00);
  endtask

  task automatic t_pulse;
    acc(0, 1, 8'h10);
    acc(1, 0, 8'h00);
    cs(3);
    check("R10 pulse flag set", {7'd0, cmd_r[1]}, 8'd1);
    ms(2);
    check("R10 pulse held after two ms", {7'd0, cmd_r[1]}, 8'd1);
    ms(1);
    check("R10 pulse released third ms", {7'd0, cmd_r[1]}, 8'd0);
    check("R10 A released", {7'd0, irq_a_n}, 8'd1);
    cs(2);
    check("R2 no repeat early", {7'd0, cmd_r[1]}, 8'd0);
    cs(1);
    check("R2 repeat alarm", {7'd0, cmd_r[1]}, 8'd1);
    ms(3);
    acc(0, 1, 8'h00);
  endtask

  task automatic t_borrow;
    acc(1, 1, 8'h00);
    acc(2, 1, 8'h01);
    cs(99);
    check("R6 no flag at 99", {7'd0, cmd_r[1]}, 8'd0);
    cs(1);
    check("R6 flag at 100", {7'd0, cmd_r[1]}, 8'd1);
  endtask

  task automatic t_zero;
    acc(2, 1, 8'h00);
    check("R3 write clears flag", {7'd0, cmd_r[1]}, 8'd0);
    cs(20);
    check("R5 zero period quiet", {7'd0, cmd_r[1]}, 8'd0);
    check("R5 A idle", {7'd0, irq_a_n}, 8'd1);
  endtask

  task automatic t_route;
    acc(0, 1, 8'h40);
    tod(1, 0);
    check("R11 tod flag set", {7'd0, cmd_r[0]}, 8'd1);
    check("R7 tod on A route 1", {7'd0, irq_a_n}, 8'd0);
    check("R7 B idle route 1", {7'd0, irq_b}, 8'd1);
    acc(0, 1, 8'h00);
    check("R7 tod on B route 0", {6'd0, irq_b, irq_a_n}, 8'b01);
    acc(0, 1, 8'h20);
    check("R9 B active high", {6'd0, irq_b, irq_b_hi}, 8'b11);
    acc(0, 1, 8'h24);
    check("R8 masked B idle", {7'd0, irq_b}, 8'd0);
    check("R8 masked flag reads", {7'd0, cmd_r[0]}, 8'd1);
    tod(0, 1);
    check("R11 ack clears", {7'd0, cmd_r[0]}, 8'd0);
    tod(1, 1);
    check("R11 set beats ack", {7'd0, cmd_r[0]}, 8'd1);
    tod(0, 1);
  endtask

  task automatic t_ro;
    acc(0, 1, 8'h03);
    check("R12 flag bits read-only", cmd_r, 8'h00);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_countdown();
    t_reload();
    t_pulse();
    t_borrow();
    t_zero();
    t_route();
    t_ro();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule